// File: doc/BRIEF.md
# Serial Port with Fill-Level Interrupts

This block is an asynchronous serial transmitter and receiver that sits on a simple register bus. Software picks the character format and the bit rate, enables each direction, and moves characters through an 8-entry transmit queue and a 12-entry receive queue. Each bit lasts sixteen ticks of an internal rate generator. The receiver checks each character it takes in and stores the error flags in the same queue word as the character.

Interrupts depend on how full the queues are, not on single characters. The transmit cause asks for more data once the transmit queue is at most half full. One receive cause reports a receive queue that holds between a third and two thirds of its capacity. The other reports data that has been left waiting while the line is quiet. Each cause is latched, and writing a one to its bit clears it. A break control holds the output line low. A loopback control sends the transmitter's line into the receiver and keeps the pin at mark.

Register map: address 0 holds the format (bit0 eight data bits, bit1 parity on, bit2 even parity, bit3 two stop bits). Address 1 holds divisor bits 11:8 in its low nibble, and address 2 holds divisor bits 7:0. Address 3 holds the controls (bit0 receive on, bit1 transmit on, bit2 break, bit3 receive interrupt enable, bit4 transmit interrupt enable, bit5 loopback). Address 4 is the data port. Address 5 holds the latched causes, and address 6 holds the live status.

Top module: `serport`

## Requirements
- R1: The 12-bit divisor N is built from address 1 bits 3:0 (upper) and address 2 bits 7:0 (lower). Every serial bit lasts 16·(N+1) clock cycles.
- R2: A transmitted frame is a 0 start bit, then 7 or 8 data bits LSB first, then an optional parity bit (even: total ones even; odd: total ones odd), then 1 or 2 stop bits at 1. The line idles at 1.
- R3: With transmit disabled (control bit1 = 0), queued characters stay queued, the line stays at 1 and busy stays 0. With receive disabled (control bit0 = 0), incoming frames are ignored.
- R4: While control bit2 is 1, the txd pin is 0. It returns to 1 once the bit is cleared, as long as no frame is being sent.
- R5: With control bit5 = 1, the receiver takes the transmitter's line and the txd pin is held at 1.
- R6: Reading address 4 pops the receive queue. The returned word holds the character in bits 7:0 (bit7 = 0 for 7-bit characters), a parity error in bit8 and a framing error (first stop bit sampled as 0) in bit9.
- R7: A character that completes while the receive queue holds 12 entries is discarded. The next character that is stored carries bit10 = 1.
- R8: Address 6 reads bit0 = transmitter busy, bit1 = receive queue not empty, bit2 = transmit queue not full.
- R9: Cause bit0 latches while the transmit queue holds 4 or fewer entries. Writing 1 to a cause bit at address 5 clears it in the next cycle.
- R10: Cause bit1 latches while the receive queue holds from 4 to 8 entries.
- R11: Cause bit2 latches when the receive queue is not empty and no start bit has been seen for three character times (48·frame-bits ticks).
- R12: irq = (cause bit0 AND control bit4) OR ((cause bit1 OR cause bit2) AND control bit3).
- R13: After reset, all registers are 0, txd = 1, irq = 0, and the status reads 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data at address 4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps the default queue depths of 8 and 12. That makes the 4-entry transmit threshold, the 4-to-8 receive window and the full 12-entry overrun case reachable with a few dozen characters. It runs mostly with divisor 1 (32-clock bits) and once with divisor 3, so the three-character idle timeout of about a thousand cycles falls well inside the run. Receive frames come either through loopback or from rxd driven by the bench, which lets it inject parity and stop-bit faults.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam logic [2:0] ADR_FMT   = 3'd0;
  localparam logic [2:0] ADR_DIVH  = 3'd1;
  localparam logic [2:0] ADR_DIVL  = 3'd2;
  localparam logic [2:0] ADR_CTL   = 3'd3;
  localparam logic [2:0] ADR_DATA  = 3'd4;
  localparam logic [2:0] ADR_CAUSE = 3'd5;
  localparam logic [2:0] ADR_STAT  = 3'd6;

  localparam int CTL_RXON = 0;
  localparam int CTL_TXON = 1;
  localparam int CTL_BRK  = 2;
  localparam int CTL_RXIE = 3;
  localparam int CTL_TXIE = 4;
  localparam int CTL_LOOP = 5;

  typedef struct packed {
    logic stop2;
    logic par_even;
    logic par_en;
    logic len8;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_t;

  function automatic logic [3:0] data_bits(frame_cfg_t c);
    return c.len8 ? 4'd8 : 4'd7;
  endfunction

  function automatic logic [3:0] frame_bits(frame_cfg_t c);
    return 4'd2 + data_bits(c) + {3'd0, c.par_en} + {3'd0, c.stop2};
  endfunction

  function automatic logic par_bit(frame_cfg_t c, logic [7:0] d);
    logic ones;
    ones = c.len8 ? ^d : ^d[6:0];
    return c.par_even ? ones : ~ones;
  endfunction

  function automatic logic [11:0] build_frame(frame_cfg_t c, logic [7:0] d);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || c.len8) f[i+1] = d[i];
    if (c.par_en) begin
      if (c.len8) f[9] = par_bit(c, d);
      else        f[8] = par_bit(c, d);
    end
    return f;
  endfunction

  function automatic logic [15:0] idle_limit(frame_cfg_t c);
    return 16'(frame_bits(c)) * 16'd48;
  endfunction

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
  parameter int W = 8,
  parameter int D = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           wdata,
  input  logic                   pop,
  output logic [W-1:0]           rdata,
  output logic [$clog2(D+1)-1:0] count,
  output logic                   full,
  output logic                   empty
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D+1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(D-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(D));
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the receiver must drop rather than push into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full));
  // R8: pops only happen while the status shows data
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));

endmodule

// File: rtl/serport_tx.sv
module serport_tx
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  frame_cfg_t cfg,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       line,
  output logic       busy
);
  logic [11:0] shreg;
  logic [3:0]  bits_left;
  logic [3:0]  os;

  assign fifo_pop = !busy && en && !fifo_empty;
  assign line     = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      os        <= '0;
    end else if (busy) begin
      if (tick) begin
        if (os == 4'd15) begin
          os    <= '0;
          shreg <= {1'b1, shreg[11:1]};
          bits_left <= bits_left - 1'b1;
          if (bits_left == 4'd1) busy <= 1'b0;
        end else begin
          os <= os + 1'b1;
        end
      end
    end else if (fifo_pop) begin
      busy      <= 1'b1;
      shreg     <= build_frame(cfg, fifo_data);
      bits_left <= frame_bits(cfg);
      os        <= '0;
    end
  end

  // R2: every frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (line == 1'b0));

endmodule

// File: rtl/serport_rx.sv
module serport_rx
  import serport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        en,
  input  frame_cfg_t  cfg,
  input  logic        rx_in,
  input  logic        fifo_full,
  output logic        push,
  output logic [10:0] push_word,
  output logic        start_seen
);
  rx_state_t  st;
  logic [1:0] sync;
  logic [3:0] os, idx;
  logic [7:0] dat;
  logic       pbit, ovr_pend;
  logic       rx_s, done, perr;

  assign rx_s       = sync[1];
  assign done       = (st == RX_STOP) && tick && (os == 4'd15);
  assign push       = done && !fifo_full;
  assign perr       = cfg.par_en && (par_bit(cfg, dat) != pbit);
  assign push_word  = {ovr_pend, !rx_s, perr, dat};
  assign start_seen = en && (st == RX_IDLE) && tick && !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE;
      os <= '0;
      idx <= '0;
      dat <= '0;
      pbit <= 1'b0;
      ovr_pend <= 1'b0;
    end else if (!en) begin
      st <= RX_IDLE;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!rx_s) begin
          st <= RX_START;
          os <= '0;
          dat <= '0;
        end
        RX_START: if (os == 4'd7) begin
          os  <= '0;
          idx <= '0;
          st  <= rx_s ? RX_IDLE : RX_DATA;
        end else os <= os + 1'b1;
        RX_DATA: if (os == 4'd15) begin
          os <= '0;
          dat[idx[2:0]] <= rx_s;
          idx <= idx + 1'b1;
          if (idx == data_bits(cfg) - 4'd1)
            st <= cfg.par_en ? RX_PAR : RX_STOP;
        end else os <= os + 1'b1;
        RX_PAR: if (os == 4'd15) begin
          os <= '0;
          pbit <= rx_s;
          st <= RX_STOP;
        end else os <= os + 1'b1;
        RX_STOP: if (os == 4'd15) begin
          os <= '0;
          st <= RX_IDLE;
          ovr_pend <= fifo_full;
        end else os <= os + 1'b1;
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R3: a disabled receiver never stores a character
  p_rx_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !push);

endmodule

// File: rtl/serport.sv
module serport
  import serport_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 12,
  parameter int DIV_W    = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int TX_HALF = TX_DEPTH / 2;
  localparam int RX_LO   = RX_DEPTH / 3;
  localparam int RX_HI   = (2 * RX_DEPTH) / 3;
  localparam int TCW     = $clog2(TX_DEPTH + 1);
  localparam int RCW     = $clog2(RX_DEPTH + 1);

  frame_cfg_t       fmt_q;
  logic [3:0]       divh_q;
  logic [7:0]       divl_q;
  logic [5:0]       ctl_q;
  logic [2:0]       cause_q;
  logic [DIV_W-1:0] div, tick_cnt;
  logic             tick;

  logic             tx_push, tx_pop, tx_full, tx_empty, tx_busy, tx_line;
  logic [7:0]       tx_head;
  logic [TCW-1:0]   tx_cnt;
  logic             rx_push, rx_pop, rx_full, rx_empty, rx_start, rx_in;
  logic [10:0]      rx_word, rx_head;
  logic [RCW-1:0]   rx_cnt;
  logic [15:0]      idle_cnt;
  logic             cond_tx, cond_win, cond_idle;
  logic [2:0]       cause_set, cause_clr;

  assign div  = DIV_W'({divh_q, divl_q});
  assign tick = (tick_cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= '0;
      divh_q <= '0;
      divl_q <= '0;
      ctl_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_FMT:  fmt_q  <= frame_cfg_t'(bus_wdata[3:0]);
        ADR_DIVH: divh_q <= bus_wdata[3:0];
        ADR_DIVL: divl_q <= bus_wdata[7:0];
        ADR_CTL:  ctl_q  <= bus_wdata[5:0];
        default:  ;
      endcase
    end
  end

  assign tx_push = bus_wr && (bus_addr == ADR_DATA) && !tx_full;
  assign rx_pop  = bus_rd && (bus_addr == ADR_DATA) && !rx_empty;

  serport_fifo #(.W(8), .D(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full),
    .empty(tx_empty));

  serport_fifo #(.W(11), .D(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt), .full(rx_full),
    .empty(rx_empty));

  serport_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl_q[CTL_TXON]),
    .cfg(fmt_q), .fifo_empty(tx_empty), .fifo_data(tx_head),
    .fifo_pop(tx_pop), .line(tx_line), .busy(tx_busy));

  assign rx_in = ctl_q[CTL_LOOP] ? tx_line : rxd;

  serport_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctl_q[CTL_RXON]),
    .cfg(fmt_q), .rx_in(rx_in), .fifo_full(rx_full), .push(rx_push),
    .push_word(rx_word), .start_seen(rx_start));

  assign txd = ctl_q[CTL_BRK] ? 1'b0 : (ctl_q[CTL_LOOP] ? 1'b1 : tx_line);

  // quiet-line timer, counted in rate ticks since the last start bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle_cnt <= '0;
    else if (rx_empty || rx_start) idle_cnt <= '0;
    else if (tick && idle_cnt != 16'hFFFF) idle_cnt <= idle_cnt + 1'b1;
  end

  assign cond_tx   = int'(tx_cnt) <= TX_HALF;
  assign cond_win  = (int'(rx_cnt) >= RX_LO) && (int'(rx_cnt) <= RX_HI);
  assign cond_idle = !rx_empty && (idle_cnt >= idle_limit(fmt_q));
  assign cause_set = {cond_idle, cond_win, cond_tx};
  assign cause_clr = (bus_wr && bus_addr == ADR_CAUSE) ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q | cause_set) & ~cause_clr;
  end

  assign irq = (cause_q[0] & ctl_q[CTL_TXIE]) |
               ((cause_q[1] | cause_q[2]) & ctl_q[CTL_RXIE]);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_FMT:   bus_rdata[3:0]  = fmt_q;
      ADR_DIVH:  bus_rdata[3:0]  = divh_q;
      ADR_DIVL:  bus_rdata[7:0]  = divl_q;
      ADR_CTL:   bus_rdata[5:0]  = ctl_q;
      ADR_DATA:  bus_rdata[10:0] = rx_empty ? 11'd0 : rx_head;
      ADR_CAUSE: bus_rdata[2:0]  = cause_q;
      ADR_STAT:  bus_rdata[2:0]  = {!tx_full, !rx_empty, tx_busy};
      default:   bus_rdata = '0;
    endcase
  end

  // R9: a write-one clear wins over a set in the same cycle
  p_cause_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CAUSE && bus_wdata[0]) |=> !cause_q[0]);
  // R10: the window cause only rises from a count inside the window
  p_window_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[1]) |-> $past(int'(rx_cnt) >= RX_LO && int'(rx_cnt) <= RX_HI));
  // R11: the idle cause only rises with data waiting
  p_idle_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause_q[2]) |-> $past(!rx_empty));
  // R5: loopback keeps the pin at mark unless break is forced
  p_loop_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_LOOP] && !ctl_q[CTL_BRK]) |-> txd);

endmodule

// File: tb/serport_bench.sv
`timescale 1ns/1ps
module serport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  serport u_serport (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected frame computed from the format fields
  function automatic logic [11:0] exp_frame(input logic [3:0] f, input logic [7:0] d, output int n);
    logic [11:0] v; int nd, p, ones;
    nd = f[0] ? 8 : 7; v = '1; v[0] = 1'b0; ones = 0;
    for (int i = 0; i < nd; i++) begin v[1+i] = d[i]; ones += d[i]; end
    p = 1 + nd;
    if (f[1]) begin v[p] = f[2] ? (ones % 2 == 1) : (ones % 2 == 0); p++; end
    n = p + (f[3] ? 2 : 1);
    return v;
  endfunction

  task automatic capture(input int n, input int per, output logic [11:0] got);
    int guard = 0;
    got = '1;
    while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    waitc(per / 2);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin waitc(per); got[i] = txd; end
  endtask

  task automatic drive(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin rxd = bits[i]; waitc(32); end
    rxd = 1'b1;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check(txd === 1'b1, "R13 txd", txd, 1);
    check(irq === 1'b0, "R13 irq", irq, 0);
    rd(3'd6, d); check(d[2:0] == 3'b100, "R13 R8 status", d[2:0], 4);
    rd(3'd5, d); check(d[2:0] == 3'b001, "R9 tx cause after reset", d[2:0], 1);
  endtask

  task automatic t_tx_frames;
    logic [11:0] e, g; int n;
    wr(3'd2, 16'd1); wr(3'd0, 16'h1); wr(3'd3, 16'h02);
    e = exp_frame(4'h1, 8'hA5, n);
    wr(3'd4, 16'hA5); capture(n, 32, g);
    check(g[9:0] == e[9:0], "R2 8N1 frame", g, e);
    waitc(80);
    wr(3'd0, 16'hE);
    e = exp_frame(4'hE, 8'h35, n);
    wr(3'd4, 16'h35); capture(n, 32, g);
    check(g[10:0] == e[10:0], "R2 7E2 frame", g, e);
    waitc(80);
    wr(3'd0, 16'h1); wr(3'd2, 16'd3);
    e = exp_frame(4'h1, 8'h0F, n);
    wr(3'd4, 16'h0F); capture(n, 64, g);
    check(g[9:0] == e[9:0], "R1 divisor 3 bit period", g, e);
    waitc(150);
    wr(3'd2, 16'd1);
  endtask

  task automatic t_enables;
    logic [15:0] d; logic [11:0] e, g; int n; bit hi = 1'b1;
    wr(3'd3, 16'h00); wr(3'd4, 16'h55);
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    check(hi, "R3 tx disabled line idle", 0, 1);
    rd(3'd6, d); check(d[0] == 1'b0, "R3 R8 busy while disabled", d[0], 0);
    wr(3'd3, 16'h02);
    e = exp_frame(4'h1, 8'h55, n); capture(n, 32, g);
    check(g[9:0] == e[9:0], "R3 held frame sent on enable", g, e);
    waitc(80);
    e = exp_frame(4'h1, 8'h42, n); drive(e, n); waitc(60);
    rd(3'd6, d); check(d[1] == 1'b0, "R3 rx disabled ignores frame", d[1], 0);
  endtask

  task automatic t_break;
    wr(3'd3, 16'h04); waitc(3); check(txd === 1'b0, "R4 break low", txd, 0);
    waitc(50); check(txd === 1'b0, "R4 break held", txd, 0);
    wr(3'd3, 16'h00); waitc(3); check(txd === 1'b1, "R4 break released", txd, 1);
  endtask

  task automatic t_loop;
    logic [15:0] d; bit hi = 1'b1;
    wr(3'd0, 16'h1); wr(3'd3, 16'h23); wr(3'd4, 16'h3C);
    for (int i = 0; i < 420; i++) begin @(negedge clk); if (txd !== 1'b1) hi = 1'b0; end
    check(hi, "R5 pin at mark in loopback", 0, 1);
    rd(3'd6, d); check(d[1] == 1'b1, "R8 rx not empty", d[1], 1);
    rd(3'd4, d); check(d[10:0] == 11'h03C, "R5 R6 loopback char", d[10:0], 'h3C);
    wr(3'd0, 16'hA); wr(3'd4, 16'h5A); waitc(440);
    rd(3'd4, d); check(d[10:0] == 11'h05A, "R6 7O2 char", d[10:0], 'h5A);
  endtask

  task automatic t_errors;
    logic [15:0] d; logic [11:0] e; int n;
    wr(3'd3, 16'h01); wr(3'd0, 16'h7);
    e = exp_frame(4'h7, 8'h81, n); e[9] = ~e[9]; drive(e, n); waitc(40);
    rd(3'd4, d); check(d[10:0] == 11'h181, "R6 parity error flag", d[10:0], 'h181);
    wr(3'd0, 16'h1);
    e = exp_frame(4'h1, 8'h22, n); drive(e, 9);
    rxd = 1'b0; waitc(24); rxd = 1'b1; waitc(80);
    rd(3'd4, d); check(d[10:0] == 11'h222, "R6 framing error flag", d[10:0], 'h222);
    rd(3'd6, d); check(d[1] == 1'b0, "R6 no spurious char", d[1], 0);
  endtask

  task automatic t_txcause;
    logic [15:0] d;
    wr(3'd3, 16'h00);
    for (int i = 0; i < 6; i++) wr(3'd4, 16'(8'h60 + i));
    wr(3'd5, 16'h7); rd(3'd5, d);
    check(d[0] == 1'b0, "R9 cleared with 6 queued", d[0], 0);
    wr(3'd3, 16'h10); waitc(2); check(irq === 1'b0, "R12 no irq after clear", irq, 0);
    wr(3'd3, 16'h12); waitc(2 * 320 + 100);
    rd(3'd5, d); check(d[0] == 1'b1, "R9 set at half", d[0], 1);
    check(irq === 1'b1, "R12 tx irq", irq, 1);
    waitc(5 * 320 + 200);
  endtask

  task automatic t_rxcauses;
    logic [15:0] d;
    wr(3'd0, 16'h1); wr(3'd3, 16'h23); wr(3'd5, 16'h7);
    for (int i = 0; i < 3; i++) wr(3'd4, 16'(8'h10 + i));
    waitc(3 * 320 + 150);
    wr(3'd5, 16'h6); rd(3'd5, d);
    check(d[2:1] == 2'b00, "R10 R11 no cause at 3 entries", d[2:1], 0);
    waitc(1100); rd(3'd5, d);
    check(d[2] == 1'b1, "R11 idle cause", d[2], 1);
    wr(3'd3, 16'h2B); waitc(2); check(irq === 1'b1, "R12 rx irq", irq, 1);
    wr(3'd3, 16'h23); wr(3'd5, 16'h7);
    wr(3'd4, 16'h13); waitc(450); rd(3'd5, d);
    check(d[1] == 1'b1, "R10 window at 4", d[1], 1);
    for (int i = 4; i < 12; i++) wr(3'd4, 16'(8'h10 + i));
    waitc(8 * 320 + 150);
    wr(3'd5, 16'h2); rd(3'd5, d);
    check(d[1] == 1'b0, "R10 window off at 12", d[1], 0);
    wr(3'd4, 16'h77); waitc(450);
    rd(3'd4, d); check(d[10:0] == 11'h010, "R7 oldest kept", d[10:0], 'h10);
    wr(3'd4, 16'h99); waitc(450);
    for (int i = 1; i < 12; i++) begin
      rd(3'd4, d); check(d[10:0] == 11'(8'h10 + i), "R7 queue order", d[10:0], 8'h10 + i);
    end
    rd(3'd4, d); check(d[10:0] == 11'h499, "R7 overrun flag", d[10:0], 'h499);
    rd(3'd6, d); check(d[1] == 1'b0, "R8 drained", d[1], 0);
  endtask

  initial begin
    waitc(5); rst_n = 1'b1; waitc(2);
    t_reset; t_tx_frames; t_enables; t_break; t_loop; t_errors; t_txcause; t_rxcauses;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule